// File: doc/BRIEF.md
# Two-Wire Bus Slave with Dual Own Address

This block is the slave half of a two-wire serial bus controller. It watches the clock and data lines and, after every START condition, shifts in an address byte. The upper seven bits of that byte are compared against two own-address slots, each with its own enable bit, and against the general-call address. On a hit the block acknowledges the byte, raises match flags and latches the direction the master asked for.

All data moves through one data register. After every acknowledged byte the block pulls the clock line low and keeps it low until software services the data register. In receive direction it waits for a read; in transmit direction it waits for a write. This lets slow software keep pace with any bus speed. A level interrupt reports a new address match. The new-match flag stays set until software clears it.

Software reaches the data, status, control and own-address registers through a simple select, write-strobe and read-strobe bus. Reads return data combinationally. Both bus lines are driven as open-drain enables: a 1 pulls the line low.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: Own-address slot 0 lives in register select 3, with bit 7 as the enable and bits 6:0 as the address. An address byte whose upper seven bits equal the slot address matches only while the enable is 1.
- R2: Own-address slot 1 lives in register select 4, with the same layout as slot 0. It matches only while its own enable bit is 1, independent of slot 0.
- R3: The address byte 0x00 is a general call. It matches only while control bit 2 is 1. The byte 0x01 is never a general call.
- R4: On a match the slave pulls SDA low during the acknowledge slot that follows the address byte. On no match it leaves SDA released and ignores the bus until the next START.
- R5: The status register is at select 1. A match sets bit 1 (match) and bit 0 (new match). Bit 2 (general-call match) is set only when the byte was the general-call address.
- R6: The least significant bit of the address byte gives the direction, with 1 meaning the master reads. It is latched into status bit 3 (transmit). When it is 1, status bit 4 (buffer empty) is also set on the match.
- R7: The irq output is high exactly when control bit 0 (global enable), control bit 1 (new-match enable) and the new-match flag are all 1. The control register is at select 2.
- R8: The new-match flag stays set until software writes the status register with bit 0 equal to 1. Data bytes never set it.
- R9: In receive direction, after each acknowledged byte (the address byte included), SCL is held low until the data register (select 0) is read. The data register then returns that byte.
- R10: In transmit direction, SCL is held low after the address acknowledge, and after every byte the master acknowledges, until the data register is written. Bits go out MSB first. A master ACK sets buffer empty again. A master NACK ends the transfer without holding SCL.
- R11: A STOP or a repeated START returns the slave to address search and clears match, general-call match, transmit and buffer empty. The new-match flag is left as it is.
- R12: After reset every register reads zero, irq is low and neither line is pulled.
- R13: The control and own-address registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the serial clock line |
| sda_i | input | 1 | Sensed level of the serial data line |
| scl_oe | output | 1 | Pull the clock line low (clock stretch) |
| sda_oe | output | 1 | Pull the data line low |
| reg_sel | input | 3 | Register select: 0 data, 1 status, 2 control, 3 and 4 own-address slots |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data read releases a receive stretch |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| irq | output | 1 | New-match interrupt request |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This lengthens the delay between a line edge and the state machine's reaction, which checks that acknowledge driving, transmit data setup and the start of a stretch all still land inside the master's low phase. The seven-bit address width and two address slots stay at their defaults. With these values, slot isolation, the general-call gate, repeated START, master NACK and stretching in both directions can all be reached with a handful of short transfers.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_W   = 7;
    localparam int BYTE_W   = ADDR_W + 1;
    localparam int NUM_OWN  = 2;
    localparam int SEL_W    = 3;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int OWN_BASE = 3;

    localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2);

    localparam logic [BYTE_W-1:0] GC_BYTE = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_HOLD,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } own_slot_t;

    typedef struct packed {
        logic buf_empty;
        logic xmit;
        logic gc_match;
        logic match;
        logic new_match;
    } status_t;

    typedef struct packed {
        logic gc_en;
        logic nm_ie;
        logic gie;
    } ctrl_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic hit;
        logic gc;
        logic dir;
    } match_t;

    function automatic logic slot_hit(own_slot_t s, logic [BYTE_W-1:0] b);
        return s.en && (s.addr == b[BYTE_W-1:1]);
    endfunction

endpackage

// File: rtl/i2cs_line_sense.sv
module i2cs_line_sense
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_c;
    logic              sda_c;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        logic scl_d;
        logic sda_d;
        if (i == 0) begin : g_first
            assign scl_d = scl_in;
            assign sda_d = sda_in;
        end else begin : g_next
            assign scl_d = scl_sh[i-1];
            assign sda_d = sda_sh[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_sh[i] <= 1'b1;
                sda_sh[i] <= 1'b1;
            end else begin
                scl_sh[i] <= scl_d;
                sda_sh[i] <= sda_d;
            end
        end
    end

    assign scl_c = scl_sh[STAGES-1];
    assign sda_c = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_c;
            sda_p <= sda_c;
        end
    end

    always_comb begin
        ev.scl      = scl_c;
        ev.sda      = sda_c;
        ev.scl_rise = scl_c && !scl_p;
        ev.scl_fall = !scl_c && scl_p;
        ev.start    = scl_c && scl_p && sda_p && !sda_c;
        ev.stop     = scl_c && scl_p && !sda_p && sda_c;
    end

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
    import i2cs_pkg::*;
#(
    parameter int N = NUM_OWN
) (
    input  own_slot_t         slots [N],
    input  logic              gc_en,
    input  logic [BYTE_W-1:0] addr_byte,
    output match_t            result
);

    logic [N-1:0] slot_hits;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign slot_hits[i] = slot_hit(slots[i], addr_byte);
    end

    logic gc_hit;
    assign gc_hit = gc_en && (addr_byte == GC_BYTE);

    always_comb begin
        result.hit = (|slot_hits) || gc_hit;
        result.gc  = gc_hit;
        result.dir = addr_byte[0];
    end

endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq
);

    line_ev_t          ev;
    match_t            hit;
    phase_e            state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] data_q;
    status_t           stat_q;
    ctrl_t             ctrl_q;
    own_slot_t         own_q [NUM_OWN];
    logic              mack_q;

    logic wr_data, rd_data, wr_stat, wr_ctrl;
    assign wr_data = reg_wr && (reg_sel == SEL_DATA);
    assign rd_data = reg_rd && (reg_sel == SEL_DATA);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

    i2cs_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .ev     (ev)
    );

    i2cs_addr_match #(.N(NUM_OWN)) u_match (
        .slots     (own_q),
        .gc_en     (ctrl_q.gc_en),
        .addr_byte (sh_q),
        .result    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_OWN; i++) begin
                own_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_OWN; i++) begin
                if (reg_wr && (reg_sel == SEL_W'(OWN_BASE + i))) begin
                    own_q[i] <= reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata[$bits(ctrl_t)-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            data_q  <= '0;
            stat_q  <= '0;
            mack_q  <= 1'b0;
        end else begin
            if (wr_stat && reg_wdata[0]) begin
                stat_q.new_match <= 1'b0;
            end
            if (wr_data) begin
                data_q           <= reg_wdata;
                stat_q.buf_empty <= 1'b0;
            end
            if (ev.start || ev.stop) begin
                state_q          <= ev.start ? ST_ADDR : ST_IDLE;
                cnt_q            <= '0;
                stat_q.match     <= 1'b0;
                stat_q.gc_match  <= 1'b0;
                stat_q.xmit      <= 1'b0;
                stat_q.buf_empty <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], ev.sda};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (ev.scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                            cnt_q <= '0;
                            if (hit.hit) begin
                                state_q          <= ST_AACK;
                                stat_q.match     <= 1'b1;
                                stat_q.gc_match  <= hit.gc;
                                stat_q.new_match <= 1'b1;
                                stat_q.xmit      <= hit.dir;
                                stat_q.buf_empty <= hit.dir;
                                data_q           <= sh_q;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK, ST_RACK: begin
                        if (ev.scl_fall) begin
                            state_q <= ST_HOLD;
                            cnt_q   <= '0;
                        end
                    end
                    ST_HOLD: begin
                        if (stat_q.xmit && wr_data) begin
                            sh_q    <= reg_wdata;
                            cnt_q   <= '0;
                            state_q <= ST_TX;
                        end else if (!stat_q.xmit && rd_data) begin
                            cnt_q   <= '0;
                            state_q <= ST_RX;
                        end
                    end
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], ev.sda};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (ev.scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                            data_q  <= sh_q;
                            state_q <= ST_RACK;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
                            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                                cnt_q   <= '0;
                                state_q <= ST_TACK;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_TACK: begin
                        if (ev.scl_rise) begin
                            mack_q <= !ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack_q) begin
                                state_q          <= ST_HOLD;
                                stat_q.buf_empty <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_oe = (state_q == ST_HOLD);
    assign sda_oe = (state_q == ST_AACK) || (state_q == ST_RACK) ||
                    ((state_q == ST_TX) && !sh_q[BYTE_W-1]);
    assign irq    = ctrl_q.gie && ctrl_q.nm_ie && stat_q.new_match;

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_DATA: reg_rdata = data_q;
            SEL_STAT: reg_rdata = 8'(stat_q);
            SEL_CTRL: reg_rdata = 8'(ctrl_q);
            default:  reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_OWN; i++) begin
            if (reg_sel == SEL_W'(OWN_BASE + i)) begin
                reg_rdata = own_q[i];
            end
        end
    end

    // Address hit at the end of the eighth bit leads to SDA pulled low.
    assert_ack_on_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && ev.scl_fall && cnt_q == CNT_W'(BYTE_W) && hit.hit
         && !ev.start && !ev.stop) |=> sda_oe);

    assert_empty_only_tx_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.buf_empty) |-> stat_q.xmit);

    assert_new_match_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.new_match && !(wr_stat && reg_wdata[0])) |=> stat_q.new_match);

    assert_rx_hold_until_read_R9: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && !stat_q.xmit && !rd_data && !ev.start && !ev.stop) |=> scl_oe);

    assert_tx_hold_until_write_R10: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && stat_q.xmit && !wr_data && !ev.start && !ev.stop) |=> scl_oe);

    assert_bus_cond_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |=> (!stat_q.xmit && !stat_q.match && !scl_oe));

endmodule

// File: tb/test_i2c_dual_addr_slave.sv
module test_i2c_dual_addr_slave;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_oe, sda_oe, irq;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl, sda;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    logic [6:0] m_addr [2];
    bit         m_en   [2];
    bit m_gc_en = 0, m_gie = 0, m_nmie = 0;
    bit m_new = 0, m_match = 0, m_gc = 0, m_xmit = 0, m_be = 0;
    bit mon_en = 0;

    always #2 clk = ~clk;

    assign scl = ~(m_scl_low | scl_oe);
    assign sda = ~(m_sda_low | sda_oe);

    i2c_dual_addr_slave #(.SYNC_STAGES(3)) i_i2c_dual_addr_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit model_ack(input logic [7:0] b);
        bit r = 0;
        for (int i = 0; i < 2; i++) if (m_en[i] && m_addr[i] == b[7:1]) r = 1;
        if (m_gc_en && b == 8'h00) r = 1;
        return r;
    endfunction

    function automatic int model_stat();
        return {m_be, m_xmit, m_gc, m_match, m_new};
    endfunction

    // per-clock comparison of irq against the model
    always @(negedge clk) begin
        if (mon_en && !done) begin
            checks++;
            if (irq !== (m_gie & m_nmie & m_new)) begin
                fails++;
                $display("FAIL R7: actual %0h expected %0h", irq, m_gie & m_nmie & m_new);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        tick(2);
        mon_en = 1;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b0;
        while (!scl) @(negedge clk);
        tick(H);
        m_sda_low = 1'b0; tick(H);
        m_match = 0; m_gc = 0; m_xmit = 0; m_be = 0;
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; tick(H);
        m_scl_low = 1'b0;
        while (!scl) @(negedge clk);
        tick(H);
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b1; tick(H);
        m_match = 0; m_gc = 0; m_xmit = 0; m_be = 0;
    endtask

    task automatic bit_xfer(input bit b, output bit s);
        m_sda_low = ~b; tick(H);
        m_scl_low = 1'b0;
        while (!scl) @(negedge clk);
        tick(H / 2);
        s = sda;
        tick(H / 2);
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            d[i] = s;
        end
        bit_xfer(~give_ack, s);
        m_sda_low = 1'b0;
    endtask

    task automatic addr_phase(input logic [7:0] b, input string req);
        bit a;
        bit e;
        mon_en = 0;
        e = model_ack(b);
        send_byte(b, a);
        check(req, a, e);
        if (e) begin
            m_match = 1; m_new = 1; m_gc = (m_gc_en && b == 8'h00);
            m_xmit = b[0]; m_be = b[0];
        end
        settle();
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        mon_en = 0;
        reg_write(3'd2, v);
        m_gie = v[0]; m_nmie = v[1]; m_gc_en = v[2];
        settle();
    endtask

    task automatic clear_new();
        mon_en = 0;
        reg_write(3'd1, 8'h01);
        m_new = 0;
        settle();
    endtask

    task automatic set_own(input int k, input logic [7:0] v);
        reg_write(3'(3 + k), v);
        m_en[k] = v[7]; m_addr[k] = v[6:0];
    endtask

    task automatic check_stat(input string req);
        logic [7:0] d;
        reg_read(3'd1, d);
        check(req, d, model_stat());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        m_en[0] = 0; m_en[1] = 0; m_addr[0] = '0; m_addr[1] = '0;
        tick(5);
        rst = 1'b0;
        tick(2);

        // R12: reset state
        check_stat("R12 status");
        check("R12 irq", irq, 0);
        check("R12 scl_oe", scl_oe, 0);
        check("R12 sda_oe", sda_oe, 0);

        set_own(0, 8'hBA);
        set_own(1, 8'h51);
        set_ctrl(8'h03);
        reg_read(3'd3, d);
        check("R13 own slot 0 readback", d, 8'hBA);
        reg_read(3'd2, d);
        check("R13 control readback", d, 8'h03);

        // R2: slot 1 disabled
        bus_start();
        addr_phase(8'hA2, "R2 disabled slot ack");
        check_stat("R2 status no match");
        bus_stop();

        // R2/R4/R5/R9: slot 1 enabled, receive
        set_own(1, 8'hD1);
        bus_start();
        addr_phase(8'hA2, "R4 ack on slot 1");
        check_stat("R5 flags after match");
        check("R7 irq on match", irq, 1);
        tick(20);
        check("R9 hold after address", scl_oe, 1);
        reg_read(3'd0, d);
        check("R9 address byte in data", d, 8'hA2);
        tick(4);
        check("R9 release after read", scl_oe, 0);
        begin
            bit a;
            send_byte(8'hC5, a);
            check("R9 data byte ack", a, 1);
        end
        tick(20);
        check("R9 hold after data", scl_oe, 1);
        reg_read(3'd0, d);
        check("R9 data byte value", d, 8'hC5);
        check_stat("R8 new match still set");
        clear_new();
        check_stat("R8 new match cleared");
        check("R7 irq after clear", irq, 0);
        begin
            bit a;
            send_byte(8'h3C, a);
            check("R9 second data ack", a, 1);
        end
        check_stat("R8 data byte keeps new clear");
        reg_read(3'd0, d);
        check("R9 second data value", d, 8'h3C);
        bus_stop();
        check_stat("R11 stop clears flags");

        // R3: general call
        bus_start();
        addr_phase(8'h00, "R3 gc disabled");
        bus_stop();
        set_ctrl(8'h07);
        bus_start();
        addr_phase(8'h00, "R3 gc enabled");
        check_stat("R5 gc flag");
        reg_read(3'd0, d);
        check("R9 gc byte", d, 8'h00);
        bus_stop();
        clear_new();
        bus_start();
        addr_phase(8'h01, "R3 byte 01 not gc");
        bus_stop();

        // R6/R10: transmit
        bus_start();
        addr_phase(8'h75, "R4 ack slot 0 read");
        check_stat("R6 transmit and empty");
        tick(20);
        check("R10 hold before first write", scl_oe, 1);
        reg_write(3'd0, 8'h96);
        m_be = 0;
        check_stat("R10 empty cleared by write");
        check("R10 release after write", scl_oe, 0);
        recv_byte(1'b1, d);
        check("R10 first byte MSB first", d, 8'h96);
        tick(20);
        check("R10 hold after master ack", scl_oe, 1);
        m_be = 1;
        check_stat("R10 empty after ack");
        reg_write(3'd0, 8'h5A);
        m_be = 0;
        recv_byte(1'b0, d);
        check("R10 second byte", d, 8'h5A);
        tick(20);
        check("R10 no hold after nack", scl_oe, 0);
        check("R10 sda released after nack", sda_oe, 0);
        bus_stop();
        check_stat("R11 stop clears transmit");

        // R7: interrupt gating
        set_ctrl(8'h05);
        check("R7 irq nm enable off", irq, 0);
        set_ctrl(8'h06);
        check("R7 irq global off", irq, 0);
        set_ctrl(8'h07);
        check("R7 irq both on", irq, 1);
        clear_new();

        // R11: repeated start
        bus_start();
        addr_phase(8'h75, "R4 ack read before restart");
        reg_write(3'd0, 8'h81);
        m_be = 0;
        recv_byte(1'b0, d);
        check("R10 byte before restart", d, 8'h81);
        bus_rstart();
        check_stat("R11 restart clears transmit");
        addr_phase(8'h74, "R4 ack write after restart");
        check_stat("R6 write direction");
        reg_read(3'd0, d);
        bus_stop();
        clear_new();

        // R1: slot 0 disabled
        set_own(0, 8'h3A);
        bus_start();
        addr_phase(8'h74, "R1 disabled slot 0");
        check_stat("R1 status no match");
        bus_stop();

        mon_en = 0;
        tick(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule